// File: doc/BRIEF.md
# CCD Digitizer Output Stage with Programmable Control Polarities

This block is the digital back end of a CCD front-end digitizer. It takes the 12-bit result of the converter and registers it on an active edge of the pixel data clock pin. Whether that edge is rising or falling is set by a configuration bit. While the blanking pin is asserted, the registered word is the 7-bit clamp reference code, zero-extended, and not the video sample. The sense of the blanking pin is also programmable. The result leaves the block on a 12-bit bus modelled as a data word plus a drive enable.

The pixel clock pin is not used as a clock. It is brought into the system clock domain through a short synchronizer chain, and the selected edge is detected there, so one system clock serves the whole block. The output-enable pin and the standby pin each have a sense bit. With one standby sense the block freezes its last output word. With the other it forces a fixed all-zero test word. The sample/hold, dummy-pixel clamp and optical-black clamp pulse pins each pass through a sense bit, so downstream logic always sees active-high strobes.

Top module: `ccd_out_stage`

## Requirements
- R1: While `rst_n` is low and after reset until the first capture, `dout_o` is all zeros.
- R2: With `edge_rise_i`=1, a low-to-high transition of `pix_clk_i` registers a new word and a high-to-low transition does not. The word appears at most SYNC_STAGES+1 system clocks after the transition.
- R3: With `edge_rise_i`=0, a high-to-low transition of `pix_clk_i` registers a new word and a low-to-high transition does not.
- R4: Blanking is active when `blank_i` equals `blank_high_i`. A word registered while blanking is active is `{5'b0, clamp_i}`; otherwise it is `sample_i`. `blank_i` is sampled on the same capture.
- R5: With `oe_sense_i`=1, `dout_en_o` is 1 exactly when `oe_i` is 0. With `oe_sense_i`=0, `dout_en_o` is 1 exactly when `oe_i` is 1.
- R6: With `stby_sense_i`=1 and `stdby_i`=1, `dout_o` keeps its last word and pixel clock edges register nothing. With `stby_sense_i`=1 and `stdby_i`=0, the block runs normally.
- R7: With `stby_sense_i`=0 and `stdby_i`=0, `dout_o` is all zeros and nothing is registered. With `stby_sense_i`=0 and `stdby_i`=1, the block runs and shows the last registered word again.
- R8: Each of `shp_o`, `shd_o` follows its pin when `shpd_high_i`=1 and is the inverse otherwise. `clpdm_o` does the same with `clpdm_high_i`, and `clpob_o` with `clpob_high_i`.
- R9: A change of `edge_rise_i` applies from the first pixel clock transition after the change. No transition is lost or doubled.
- R10: `dout_o` does not change while the block is running and no active pixel clock edge has been detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_clk_i | input | 1 | Pixel data clock pin, treated as data |
| sample_i | input | 12 | Converter result, bit 0 is LSB |
| clamp_i | input | 7 | Clamp reference code |
| blank_i | input | 1 | Blanking pin |
| oe_i | input | 1 | Output enable pin |
| stdby_i | input | 1 | Standby pin |
| shp_i | input | 1 | Reset-level sample pulse pin |
| shd_i | input | 1 | Data-level sample pulse pin |
| clpdm_i | input | 1 | Dummy-pixel clamp pulse pin |
| clpob_i | input | 1 | Optical-black clamp pulse pin |
| edge_rise_i | input | 1 | 1 = rising pixel clock edge captures |
| blank_high_i | input | 1 | 1 = blanking pin active high |
| oe_sense_i | input | 1 | Output enable sense select |
| stby_sense_i | input | 1 | Standby sense select |
| shpd_high_i | input | 1 | 1 = sample pulses active high |
| clpdm_high_i | input | 1 | 1 = dummy clamp pulse active high |
| clpob_high_i | input | 1 | 1 = black clamp pulse active high |
| dout_o | output | 12 | Output word |
| dout_en_o | output | 1 | Output drive enable (0 = high impedance) |
| shp_o | output | 1 | Normalized active-high strobe |
| shd_o | output | 1 | Normalized active-high strobe |
| clpdm_o | output | 1 | Normalized active-high strobe |
| clpob_o | output | 1 | Normalized active-high strobe |

## Verification
The hardest case to reach is a change of edge polarity or standby state between two pixel clock transitions. The effect depends on which of the two transitions comes next, and a wrong design differs from a correct one only by a single missed or extra capture. Directed sequences flip `edge_rise_i` while the pixel clock sits at each level, then drive both transitions. Standby is entered and left around captures with the input word changed in between. The random phase redraws the sense bits between transitions, so these crossings also occur many times without a fixed pattern.

// File: rtl/ccdo_pkg.sv
package ccdo_pkg;

  typedef enum logic [1:0] {
    MODE_RUN    = 2'd0,
    MODE_FREEZE = 2'd1,
    MODE_TEST   = 2'd2
  } ccdo_mode_t;

endpackage

// File: rtl/ccdo_edge_sel.sv
module ccdo_edge_sel #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pix_i,
  input  logic rise_sel_i,
  output logic act_edge_o
);

  localparam int TOP = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;
  logic                   last_q;
  logic                   last_d;
  logic                   rise_seen;
  logic                   fall_seen;

  // synchronizer chain, one stage per generate pass
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_head
      assign sync_d[g] = pix_i;
    end else begin : g_tail
      assign sync_d[g] = sync_q[g-1];
    end
  end

  always_comb begin
    last_d    = sync_q[TOP];
    rise_seen = sync_q[TOP] & ~last_q;
    fall_seen = ~sync_q[TOP] & last_q;
    act_edge_o = rise_sel_i ? rise_seen : fall_seen;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= last_d;
    end
  end

endmodule

// File: rtl/ccdo_ctrl_decode.sv
module ccdo_ctrl_decode
  import ccdo_pkg::*;
(
  input  logic       stdby_i,
  input  logic       stby_sense_i,
  input  logic       oe_i,
  input  logic       oe_sense_i,
  input  logic       blank_i,
  input  logic       blank_high_i,
  input  logic [3:0] pulse_i,
  input  logic [3:0] pulse_high_i,
  output ccdo_mode_t mode_o,
  output logic       drive_en_o,
  output logic       blank_act_o,
  output logic [3:0] strobe_o
);

  always_comb begin
    if (stby_sense_i) begin
      mode_o = stdby_i ? MODE_FREEZE : MODE_RUN;
    end else begin
      mode_o = stdby_i ? MODE_RUN : MODE_TEST;
    end
    drive_en_o  = oe_sense_i ? ~oe_i : oe_i;
    blank_act_o = ~(blank_i ^ blank_high_i);
  end

  for (genvar p = 0; p < 4; p++) begin : g_pulse
    assign strobe_o[p] = pulse_high_i[p] ? pulse_i[p] : ~pulse_i[p];
  end

endmodule

// File: rtl/ccdo_out_reg.sv
module ccdo_out_reg
  import ccdo_pkg::*;
#(
  parameter int DATA_W  = 12,
  parameter int CLAMP_W = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cap_i,
  input  ccdo_mode_t         mode_i,
  input  logic               blank_act_i,
  input  logic [DATA_W-1:0]  sample_i,
  input  logic [CLAMP_W-1:0] clamp_i,
  output logic [DATA_W-1:0]  dout_o
);

  localparam int PAD_W = DATA_W - CLAMP_W;

  logic [DATA_W-1:0] word_q;
  logic [DATA_W-1:0] word_d;
  logic [DATA_W-1:0] clamp_ext;
  logic              load_en;

  always_comb begin
    clamp_ext = {{PAD_W{1'b0}}, clamp_i};
    load_en   = cap_i && (mode_i == MODE_RUN);
    word_d    = word_q;
    if (load_en) begin
      word_d = blank_act_i ? clamp_ext : sample_i;
    end
    dout_o = (mode_i == MODE_TEST) ? '0 : word_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (load_en) begin
      word_q <= word_d;
    end
  end

endmodule

// File: rtl/ccd_out_stage.sv
module ccd_out_stage
  import ccdo_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int CLAMP_W     = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pix_clk_i,
  input  logic [DATA_W-1:0]  sample_i,
  input  logic [CLAMP_W-1:0] clamp_i,
  input  logic               blank_i,
  input  logic               oe_i,
  input  logic               stdby_i,
  input  logic               shp_i,
  input  logic               shd_i,
  input  logic               clpdm_i,
  input  logic               clpob_i,
  input  logic               edge_rise_i,
  input  logic               blank_high_i,
  input  logic               oe_sense_i,
  input  logic               stby_sense_i,
  input  logic               shpd_high_i,
  input  logic               clpdm_high_i,
  input  logic               clpob_high_i,
  output logic [DATA_W-1:0]  dout_o,
  output logic               dout_en_o,
  output logic               shp_o,
  output logic               shd_o,
  output logic               clpdm_o,
  output logic               clpob_o
);

  logic       act_edge;
  ccdo_mode_t mode;
  logic       blank_act;
  logic [3:0] strobe;

  ccdo_edge_sel #(
    .SYNC_STAGES(SYNC_STAGES)
  ) edge_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .pix_i     (pix_clk_i),
    .rise_sel_i(edge_rise_i),
    .act_edge_o(act_edge)
  );

  ccdo_ctrl_decode ctrl_i (
    .stdby_i     (stdby_i),
    .stby_sense_i(stby_sense_i),
    .oe_i        (oe_i),
    .oe_sense_i  (oe_sense_i),
    .blank_i     (blank_i),
    .blank_high_i(blank_high_i),
    .pulse_i     ({clpob_i, clpdm_i, shd_i, shp_i}),
    .pulse_high_i({clpob_high_i, clpdm_high_i, shpd_high_i, shpd_high_i}),
    .mode_o      (mode),
    .drive_en_o  (dout_en_o),
    .blank_act_o (blank_act),
    .strobe_o    (strobe)
  );

  ccdo_out_reg #(
    .DATA_W (DATA_W),
    .CLAMP_W(CLAMP_W)
  ) oreg_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap_i      (act_edge),
    .mode_i     (mode),
    .blank_act_i(blank_act),
    .sample_i   (sample_i),
    .clamp_i    (clamp_i),
    .dout_o     (dout_o)
  );

  assign shp_o   = strobe[0];
  assign shd_o   = strobe[1];
  assign clpdm_o = strobe[2];
  assign clpob_o = strobe[3];

endmodule

// File: rtl/ccdo_chk.sv
module ccdo_chk #(
  parameter int DATA_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cap_stb,
  input logic [DATA_W-1:0] dout_o,
  input logic              dout_en_o,
  input logic              oe_i,
  input logic              oe_sense_i,
  input logic              stdby_i,
  input logic              stby_sense_i,
  input logic              shp_i,
  input logic              shpd_high_i,
  input logic              shp_o
);

  logic run_st;
  logic frz_st;
  assign run_st = stby_sense_i ? !stdby_i : stdby_i;
  assign frz_st = stby_sense_i && stdby_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_zero_R1: assert (dout_o == '0)
        else $error("reset word not zero");
    end
  end

  assert_oe_low_drives_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_sense_i && !oe_i) |-> dout_en_o);

  assert_oe_inv_floats_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_sense_i && !oe_i) |-> !dout_en_o);

  assert_freeze_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (frz_st && $past(frz_st)) |-> $stable(dout_o));

  assert_test_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!stby_sense_i && !stdby_i) |-> (dout_o == '0));

  assert_strobe_norm_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !shpd_high_i |-> (shp_o != shp_i));

  assert_quiet_no_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (run_st && !cap_stb) |=> ($stable(dout_o) || !run_st));

endmodule

bind ccd_out_stage ccdo_chk #(.DATA_W(DATA_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .cap_stb     (act_edge),
  .dout_o      (dout_o),
  .dout_en_o   (dout_en_o),
  .oe_i        (oe_i),
  .oe_sense_i  (oe_sense_i),
  .stdby_i     (stdby_i),
  .stby_sense_i(stby_sense_i),
  .shp_i       (shp_i),
  .shpd_high_i (shpd_high_i),
  .shp_o       (shp_o)
);

// File: tb/ccd_out_stage_tb_top.sv
module ccd_out_stage_tb_top;

  localparam int DW = 12;
  localparam int CW = 7;

  logic clk = 1'b0;
  logic rst_n;
  logic pix_clk_i, blank_i, oe_i, stdby_i;
  logic shp_i, shd_i, clpdm_i, clpob_i;
  logic edge_rise_i, blank_high_i, oe_sense_i, stby_sense_i;
  logic shpd_high_i, clpdm_high_i, clpob_high_i;
  logic [DW-1:0] sample_i;
  logic [CW-1:0] clamp_i;
  logic [DW-1:0] dout_o;
  logic dout_en_o, shp_o, shd_o, clpdm_o, clpob_o;

  int n_chk = 0;
  int n_err = 0;
  logic [DW-1:0] held;   // model of the registered word

  always #2.5 clk = ~clk;

  ccd_out_stage dut_i (.*);

  function automatic logic [DW-1:0] cap_word(input logic blk, input logic bh,
      input logic [CW-1:0] cl, input logic [DW-1:0] s);
    return (blk == bh) ? {{(DW-CW){1'b0}}, cl} : s;
  endfunction

  function automatic int mode_of(input logic sense, input logic pin);
    if (sense) return pin ? 1 : 0;   // 0 run, 1 freeze, 2 test
    return pin ? 0 : 2;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // drive one pixel clock transition and update the model
  task automatic pix_to(input logic lvl);
    logic rising;
    rising = lvl && !pix_clk_i;
    if (lvl != pix_clk_i) begin
      if ((rising == edge_rise_i) && mode_of(stby_sense_i, stdby_i) == 0)
        held = cap_word(blank_i, blank_high_i, clamp_i, sample_i);
    end
    pix_clk_i = lvl;
    tick(6);
  endtask

  function automatic logic [DW-1:0] exp_out();
    return (mode_of(stby_sense_i, stdby_i) == 2) ? '0 : held;
  endfunction

  initial begin
    #(200000 * 5);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d5a));
    rst_n = 1'b0; pix_clk_i = 0; blank_i = 0; oe_i = 0; stdby_i = 0;
    shp_i = 0; shd_i = 0; clpdm_i = 0; clpob_i = 0;
    edge_rise_i = 1; blank_high_i = 1; oe_sense_i = 1; stby_sense_i = 1;
    shpd_high_i = 1; clpdm_high_i = 1; clpob_high_i = 1;
    sample_i = '0; clamp_i = '0; held = '0;
    tick(3);
    chk("R1 in reset", dout_o, 0);
    rst_n = 1'b1;
    sample_i = 12'hABC;
    tick(4);
    chk("R1 after reset", dout_o, 0);

    // R2: rising selected
    pix_to(1); chk("R2 rise captures", dout_o, 12'hABC);
    sample_i = 12'h123;
    pix_to(0); chk("R2 fall ignored", dout_o, 12'hABC);

    // R3: falling selected
    edge_rise_i = 0;
    pix_to(1); chk("R3 rise ignored", dout_o, 12'hABC);
    pix_to(0); chk("R3 fall captures", dout_o, 12'h123);

    // R9: switch polarity while low, then while high
    edge_rise_i = 1; sample_i = 12'h5A5;
    pix_to(1); chk("R9 new rise edge used", dout_o, 12'h5A5);
    edge_rise_i = 0; sample_i = 12'h0F0;
    pix_to(0); chk("R9 new fall edge used", dout_o, 12'h0F0);

    // R4: blanking both senses, clamp zero-extended
    edge_rise_i = 1; blank_high_i = 1; blank_i = 1; clamp_i = 7'h7F;
    pix_to(1); chk("R4 blank high clamp", dout_o, 12'h07F);
    pix_to(0);
    blank_high_i = 0; blank_i = 1; sample_i = 12'hFFF;
    pix_to(1); chk("R4 blank low inactive", dout_o, 12'hFFF);
    pix_to(0);
    blank_i = 0; clamp_i = 7'h15;
    pix_to(1); chk("R4 blank low active", dout_o, 12'h015);
    pix_to(0);
    blank_high_i = 1;

    // R5: output enable senses
    oe_sense_i = 1; oe_i = 0; tick(1); chk("R5 sense1 oe0", dout_en_o, 1);
    oe_i = 1; tick(1); chk("R5 sense1 oe1", dout_en_o, 0);
    oe_sense_i = 0; tick(1); chk("R5 sense0 oe1", dout_en_o, 1);
    oe_i = 0; tick(1); chk("R5 sense0 oe0", dout_en_o, 0);

    // R6: freeze
    stby_sense_i = 1; stdby_i = 0; sample_i = 12'h321;
    pix_to(1); chk("R6 run before freeze", dout_o, 12'h321);
    stdby_i = 1; sample_i = 12'h999;
    pix_to(0); pix_to(1); chk("R6 frozen word", dout_o, 12'h321);
    stdby_i = 0; pix_to(0); pix_to(1); chk("R6 run after freeze", dout_o, 12'h999);

    // R7: test word
    stby_sense_i = 0; stdby_i = 0; tick(1); chk("R7 test zeros", dout_o, 0);
    sample_i = 12'h444; pix_to(0); pix_to(1); chk("R7 test no capture", dout_o, 0);
    stdby_i = 1; tick(1); chk("R7 run restores word", dout_o, 12'h999);
    pix_to(0); pix_to(1); chk("R7 run captures", dout_o, 12'h444);

    // R8: strobe normalization
    for (int i = 0; i < 16; i++) begin
      {shpd_high_i, clpdm_high_i, clpob_high_i} = 3'($urandom);
      {shp_i, shd_i, clpdm_i, clpob_i} = 4'($urandom);
      tick(1);
      chk("R8 shp", shp_o, shpd_high_i ? shp_i : !shp_i);
      chk("R8 shd", shd_o, shpd_high_i ? shd_i : !shd_i);
      chk("R8 clpdm", clpdm_o, clpdm_high_i ? clpdm_i : !clpdm_i);
      chk("R8 clpob", clpob_o, clpob_high_i ? clpob_i : !clpob_i);
    end

    // random mix of all settings (R2 R3 R4 R6 R7 R9 R10)
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(3) == 0) begin
        edge_rise_i  = 1'($urandom);
        blank_high_i = 1'($urandom);
        stby_sense_i = 1'($urandom);
        stdby_i = ($urandom_range(9) < 7) ? !stby_sense_i : stby_sense_i;
      end
      oe_sense_i = 1'($urandom); oe_i = 1'($urandom);
      sample_i = 12'($urandom); clamp_i = 7'($urandom); blank_i = 1'($urandom);
      tick(1);
      chk("R5 random", dout_en_o, oe_sense_i ? !oe_i : oe_i);
      chk("R10 no change before edge", dout_o, exp_out());
      pix_to(!pix_clk_i);
      chk("R2 R3 R4 R6 R7 random capture", dout_o, exp_out());
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule